// File: doc/BRIEF.md
# Scoreboard Issue and Dispatch Control

This block is the control for an out-of-order-completion floating-point back end. Issue and operand dispatch are split into two separate points. One instruction at a time waits in the instruction register. It issues in program order into a one-entry staging slot that belongs to the functional unit it needs. The slot must be free, or be emptying in that same cycle, and no issued, uncompleted instruction may already write the same destination. A stall for missing operands therefore never holds the in-order stream. Only a busy slot or a WAW conflict does.

Each occupied staging slot dispatches on its own to its unit. It does so once the unit can accept work and every source that was still being produced at issue time has been written. A later, independent instruction held in another unit's slot can therefore dispatch and complete while an earlier one waits. The adder is a four-stage pipeline. The multiplier (four cycles) and the divider (six cycles) each accept one operation at a time.

The block models control only. Data values, register-file reads and result write-back belong to neighbouring logic. That logic uses the dispatch read-port numbers and the completion pulses this block emits.

Top module: `sb_issue_ctrl`

## Requirements
- R1: After reset no register is marked busy, every staging slot is empty, no dispatch or completion is signalled, and `ir_ready` is low while `ir_valid` is low.
- R2: `ir_ready` is high exactly when `ir_valid` is high, `ir_unit` is a known code (0 = adder, 1 = multiplier, 2 = divider), the staging slot of that unit is empty or dispatching in this cycle, and the destination is not busy. Code 3 never issues and marks no register busy. A RAW dependence does not stop issue.
- R3: At most one issued, uncompleted instruction writes a given register. `reg_busy[d]` is set at the issue edge and cleared at the edge that ends the completion cycle for `d`.
- R4: While the instruction register is stalled, nothing behind it is taken, even when that later instruction's unit is idle.
- R5: A staged instruction dispatches in the first cycle in which its unit is free and all of its waited-on sources are written. During that cycle `disp_rs1`/`disp_rs2` of its unit carry its source numbers.
- R6: `cmp_valid[u]` pulses for one cycle, with `cmp_dst` set to the destination, in the LAT-th cycle after the dispatch edge. LAT is 4 for the adder, 4 for the multiplier and 6 for the divider.
- R7: The adder accepts a dispatch every cycle. The multiplier and divider accept the next dispatch no earlier than the cycle after their completion cycle.
- R8: An independent instruction issued later into another unit may dispatch and complete before an earlier staged instruction that is still waiting for an operand.
- R9: Source readiness is captured at issue. A register written by a later-issued instruction never delays an earlier staged reader, and a source equal to the instruction's own destination is ready.
- R10: A source whose producer completes in the issue cycle counts as already written.
- R11: A staging slot that dispatches in a cycle can accept a new instruction at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_valid | input | 1 | Instruction register holds an instruction |
| ir_unit | input | 2 | Unit code: 0 adder, 1 multiplier, 2 divider, 3 none |
| ir_dst | input | REG_W | Destination register number |
| ir_src1 | input | REG_W | First source register number |
| ir_src2 | input | REG_W | Second source register number |
| ir_ready | output | 1 | Instruction issues at this edge |
| disp_valid | output | NU | Per-unit dispatch this cycle |
| disp_rs1 | output | NU*REG_W | Per-unit first read-port register number |
| disp_rs2 | output | NU*REG_W | Per-unit second read-port register number |
| cmp_valid | output | NU | Per-unit completion pulse |
| cmp_dst | output | NU*REG_W | Per-unit completing destination |
| stage_busy | output | NU | Per-unit staging slot occupied |
| reg_busy | output | NREG | Register has an in-flight producer |

## Verification
The bench targets these corner cases:

- **Overtaking (R8).** It replays the divide / dependent add / independent multiply sequence. It expects the multiply to finish long before the add. A design that kept the RAW stall at the issue point would complete the multiply late.
- **Readiness captured at issue (R9).** A later divide writes a source of a waiting multiply. A design that re-examined live busy bits at dispatch would hold the multiply until that divide finished.
- **Issue in the producer's completion cycle (R10).** Without the same-cycle bypass the consumer would wait forever, and its completion would never appear.
- **Slot refill and head-of-line blocking (R11, R4).** Back-to-back multiplies and a WAW-stalled add with an idle unit behind it check the exact issue edges. A one-cycle error in slot refill, counter release or in-order blocking shifts those edges.

// File: rtl/sb_pkg.sv
// Package: shared unit codes and counts for the scoreboard issue control.
// Assumes exactly three functional unit kinds, indexed by their code.
package sb_pkg;
    typedef enum logic [1:0] {
        UNIT_ADD  = 2'd0,
        UNIT_MUL  = 2'd1,
        UNIT_DIV  = 2'd2,
        UNIT_NONE = 2'd3
    } unit_e;

    localparam int NUM_UNITS = 3;
    localparam int UNIT_W    = 2;
endpackage

// File: rtl/sb_prod_table.sv
// Producer table: one busy bit and one producing-unit tag per register.
// A register with no producer is ready. Set happens at issue, clear at the
// edge that ends a completion. Assumes the issuer never sets a busy register.
module sb_prod_table #(
    parameter int NREG   = 32,
    parameter int UNIT_W = 2,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         set_en,
    input  logic [REG_W-1:0]             set_reg,
    input  logic [UNIT_W-1:0]            set_unit,
    input  logic [NREG-1:0]              clr_vec,
    output logic [NREG-1:0]              busy,
    output logic [NREG-1:0][UNIT_W-1:0]  owner
);

    // Purpose: track the in-flight producer of every register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= '0;
            owner <= '0;
        end else begin
            for (int r = 0; r < NREG; r++) begin
                if (clr_vec[r]) begin
                    busy[r] <= 1'b0;
                end
                if (set_en && (set_reg == REG_W'(r))) begin
                    busy[r]  <= 1'b1;
                    owner[r] <= set_unit;
                end
            end
        end
    end

    // R3: a register gains a second writer never
    assert_single_writer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !busy[set_reg]);

    // R6: only an in-flight register can be completed
    assert_clear_inflight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec & ~busy) == '0);

endmodule

// File: rtl/sb_stage_slot.sv
// Staging slot: holds one issued instruction for a unit until dispatch.
// Each source carries a wait bit captured at issue. The bit clears when the
// producer of that register completes. Assumes load only when empty or
// dispatching.
module sb_stage_slot #(
    parameter int NREG   = 32,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REG_W-1:0] ld_dst,
    input  logic [REG_W-1:0] ld_s1,
    input  logic [REG_W-1:0] ld_s2,
    input  logic             ld_w1,
    input  logic             ld_w2,
    input  logic             fire,
    input  logic [NREG-1:0]  clr_vec,
    output logic             vld,
    output logic [REG_W-1:0] dst,
    output logic [REG_W-1:0] s1,
    output logic [REG_W-1:0] s2,
    output logic             ready
);

    logic w1, w2;

    // Purpose: capture a new instruction, drop it on dispatch, release waits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= 1'b0;
            w1  <= 1'b0;
            w2  <= 1'b0;
            dst <= '0;
            s1  <= '0;
            s2  <= '0;
        end else if (load) begin
            vld <= 1'b1;
            dst <= ld_dst;
            s1  <= ld_s1;
            s2  <= ld_s2;
            w1  <= ld_w1;
            w2  <= ld_w2;
        end else begin
            if (fire) begin
                vld <= 1'b0;
            end
            w1 <= w1 & ~clr_vec[s1];
            w2 <= w2 & ~clr_vec[s2];
        end
    end

    // Purpose: the slot may dispatch once no source is still awaited.
    assign ready = vld & ~w1 & ~w2;

    // R11: a load never overwrites an instruction that is not leaving
    assert_load_free_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!vld || fire));

    // R5: a dispatched instruction leaves the slot unless refilled
    assert_fire_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !load) |=> !vld);

endmodule

// File: rtl/sb_exec_timer.sv
// Execution timing model of one functional unit. The pipelined variant
// shifts a token through LAT stages. The non-pipelined variant counts LAT
// cycles down and refuses work until the count reaches zero. done pulses in
// the LAT-th cycle after the start edge. Assumes LAT >= 2.
module sb_exec_timer #(
    parameter int LAT       = 4,
    parameter bit PIPELINED = 1'b0,
    parameter int REG_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REG_W-1:0] start_dst,
    output logic             free,
    output logic             done,
    output logic [REG_W-1:0] done_dst
);

    generate
        if (PIPELINED) begin : g_pipe
            logic [LAT-1:0]   tok;
            logic [REG_W-1:0] tdst [LAT];

            // Purpose: advance every token one stage per cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tok <= '0;
                    for (int i = 0; i < LAT; i++) tdst[i] <= '0;
                end else begin
                    tok[0]  <= start;
                    tdst[0] <= start_dst;
                    for (int i = 1; i < LAT; i++) begin
                        tok[i]  <= tok[i-1];
                        tdst[i] <= tdst[i-1];
                    end
                end
            end

            assign free     = 1'b1;
            assign done     = tok[LAT-1];
            assign done_dst = tdst[LAT-1];
        end else begin : g_seq
            localparam int CW = $clog2(LAT + 1);
            logic [CW-1:0]    cnt;
            logic [REG_W-1:0] dst_q;

            // Purpose: count the single operation in flight down to zero.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt   <= '0;
                    dst_q <= '0;
                end else if (start) begin
                    cnt   <= CW'(LAT);
                    dst_q <= start_dst;
                end else if (cnt != '0) begin
                    cnt <= cnt - CW'(1);
                end
            end

            assign free     = (cnt == '0);
            assign done     = (cnt == CW'(1));
            assign done_dst = dst_q;

            // R7: no second operation while one is executing
            assert_start_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
                start |-> (cnt == '0));

            // R7: the unit is free again right after completing
            assert_free_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
                done |=> (cnt == '0));
        end
    endgenerate

endmodule

// File: rtl/sb_issue_ctrl.sv
// Scoreboard issue and dispatch control (top).
// In-order issue from the instruction register into per-unit staging slots,
// limited only by a busy slot or a WAW conflict. Out-of-order dispatch from
// each slot once its unit is free and its awaited sources are written.
// Assumes the producer of ir_* holds the instruction until ir_ready.
module sb_issue_ctrl #(
    parameter int NREG    = 32,
    parameter int ADD_LAT = 4,
    parameter int MUL_LAT = 4,
    parameter int DIV_LAT = 6,
    localparam int REG_W  = $clog2(NREG),
    localparam int NU     = sb_pkg::NUM_UNITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ir_valid,
    input  logic [1:0]          ir_unit,
    input  logic [REG_W-1:0]    ir_dst,
    input  logic [REG_W-1:0]    ir_src1,
    input  logic [REG_W-1:0]    ir_src2,
    output logic                ir_ready,
    output logic [NU-1:0]       disp_valid,
    output logic [NU*REG_W-1:0] disp_rs1,
    output logic [NU*REG_W-1:0] disp_rs2,
    output logic [NU-1:0]       cmp_valid,
    output logic [NU*REG_W-1:0] cmp_dst,
    output logic [NU-1:0]       stage_busy,
    output logic [NREG-1:0]     reg_busy
);
    import sb_pkg::*;

    logic [NU-1:0]    slot_vld, slot_rdy, unit_free, slot_fire, slot_load, done;
    logic [REG_W-1:0] slot_dst [NU];
    logic [REG_W-1:0] slot_s1  [NU];
    logic [REG_W-1:0] slot_s2  [NU];
    logic [REG_W-1:0] done_dst [NU];
    logic [NREG-1:0]  clr_vec;
    logic [NREG-1:0][UNIT_W-1:0] owner;
    logic             slot_open, issue_fire, wait1, wait2;

    // Purpose: one-hot clear vector of the registers completing this cycle.
    always_comb begin
        clr_vec = '0;
        for (int u = 0; u < NU; u++) begin
            if (done[u]) clr_vec[done_dst[u]] = 1'b1;
        end
    end

    // Purpose: is the staging slot of the requested unit able to take work.
    always_comb begin
        slot_open = 1'b0;
        for (int u = 0; u < NU; u++) begin
            if (ir_unit == 2'(u)) slot_open = !slot_vld[u] || slot_fire[u];
        end
    end

    // Purpose: in-order issue decision (structural and WAW only).
    assign issue_fire = ir_valid && slot_open && !reg_busy[ir_dst];
    assign ir_ready   = issue_fire;

    // Purpose: capture which sources still await a producer at issue.
    assign wait1 = reg_busy[ir_src1] && !clr_vec[ir_src1];
    assign wait2 = reg_busy[ir_src2] && !clr_vec[ir_src2];

    sb_prod_table #(
        .NREG   (NREG),
        .UNIT_W (UNIT_W)
    ) prod_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (issue_fire),
        .set_reg  (ir_dst),
        .set_unit (ir_unit),
        .clr_vec  (clr_vec),
        .busy     (reg_busy),
        .owner    (owner)
    );

    generate
        for (genvar u = 0; u < NU; u++) begin : g_unit
            localparam int LAT_U = (u == int'(UNIT_ADD)) ? ADD_LAT :
                                   (u == int'(UNIT_MUL)) ? MUL_LAT : DIV_LAT;
            localparam bit PIPE_U = (u == int'(UNIT_ADD));

            // Purpose: route the issuing instruction to this unit's slot.
            assign slot_load[u] = issue_fire && (ir_unit == 2'(u));
            // Purpose: dispatch when operands are ready and the unit is free.
            assign slot_fire[u] = slot_rdy[u] && unit_free[u];

            sb_stage_slot #(
                .NREG (NREG)
            ) slot_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .load    (slot_load[u]),
                .ld_dst  (ir_dst),
                .ld_s1   (ir_src1),
                .ld_s2   (ir_src2),
                .ld_w1   (wait1),
                .ld_w2   (wait2),
                .fire    (slot_fire[u]),
                .clr_vec (clr_vec),
                .vld     (slot_vld[u]),
                .dst     (slot_dst[u]),
                .s1      (slot_s1[u]),
                .s2      (slot_s2[u]),
                .ready   (slot_rdy[u])
            );

            sb_exec_timer #(
                .LAT       (LAT_U),
                .PIPELINED (PIPE_U),
                .REG_W     (REG_W)
            ) timer_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .start     (slot_fire[u]),
                .start_dst (slot_dst[u]),
                .free      (unit_free[u]),
                .done      (done[u]),
                .done_dst  (done_dst[u])
            );

            assign disp_rs1[u*REG_W +: REG_W] = slot_s1[u];
            assign disp_rs2[u*REG_W +: REG_W] = slot_s2[u];
            assign cmp_dst[u*REG_W +: REG_W]  = done_dst[u];

            // R6: a completion belongs to the unit recorded as producer
            assert_owner_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
                done[u] |-> (reg_busy[done_dst[u]] && owner[done_dst[u]] == 2'(u)));
        end
    endgenerate

    assign disp_valid = slot_fire;
    assign cmp_valid  = done;
    assign stage_busy = slot_vld;

    // R2: the unknown unit code never issues
    assert_no_issue_unknown_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire |-> (ir_unit != UNIT_NONE));

    // R3: an issued destination is busy right after the issue edge
    assert_dst_marked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire |=> reg_busy[$past(ir_dst)]);

endmodule

// File: tb/sb_issue_ctrl_tb_top.sv
module sb_issue_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NREG  = 32;
    localparam int REG_W = 5;
    localparam int NU    = 3;
    localparam int U_ADD = 0, U_MUL = 1, U_DIV = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ir_valid = 1'b0;
    logic [1:0] ir_unit = 2'd0;
    logic [REG_W-1:0] ir_dst = '0, ir_src1 = '0, ir_src2 = '0;
    logic ir_ready;
    logic [NU-1:0] disp_valid, cmp_valid, stage_busy;
    logic [NU*REG_W-1:0] disp_rs1, disp_rs2, cmp_dst;
    logic [NREG-1:0] reg_busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 1'b0;

    typedef struct { int cyc; int unit; int dst; } exp_t;
    exp_t exp_q[$];

    sb_issue_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ir_valid(ir_valid), .ir_unit(ir_unit),
        .ir_dst(ir_dst), .ir_src1(ir_src1), .ir_src2(ir_src2),
        .ir_ready(ir_ready), .disp_valid(disp_valid), .disp_rs1(disp_rs1),
        .disp_rs2(disp_rs2), .cmp_valid(cmp_valid), .cmp_dst(cmp_dst),
        .stage_busy(stage_busy), .reg_busy(reg_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic expect_cmp(input int c, input int u, input int d);
        exp_t e;
        e.cyc = c; e.unit = u; e.dst = d;
        exp_q.push_back(e);
    endtask

    // Driver: present one instruction, hold it until it issues, return the issue edge.
    task automatic issue(input int u, input int d, input int a, input int b, output int edge_no);
        @(negedge clk);
        ir_valid = 1'b1;
        ir_unit  = 2'(u);
        ir_dst   = REG_W'(d);
        ir_src1  = REG_W'(a);
        ir_src2  = REG_W'(b);
        #1;
        while (!ir_ready) begin
            @(negedge clk);
            #1;
        end
        edge_no = cyc + 1;
        @(posedge clk);
    endtask

    task automatic idle_until(input int t);
        @(negedge clk);
        ir_valid = 1'b0;
        while (cyc < t) @(negedge clk);
    endtask

    // Monitor: every completion must match a queued expectation (R6).
    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            for (int u = 0; u < NU; u++) begin
                if (cmp_valid[u]) begin
                    int d;
                    bit found;
                    d = int'(cmp_dst[u*REG_W +: REG_W]);
                    found = 1'b0;
                    for (int i = 0; i < exp_q.size(); i++) begin
                        if (!found && exp_q[i].unit == u && exp_q[i].dst == d
                            && exp_q[i].cyc == cyc) begin
                            exp_q.delete(i);
                            found = 1'b1;
                        end
                    end
                    chk(found, "R6 completion unit/dst/cycle", u * 100 + d, -1);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        int ea, eb, ec, ed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state
        chk(reg_busy == '0, "R1 reg_busy", int'(reg_busy), 0);
        chk(stage_busy == '0, "R1 stage_busy", int'(stage_busy), 0);
        chk(cmp_valid == '0 && disp_valid == '0, "R1 no activity",
            int'({cmp_valid, disp_valid}), 0);
        chk(!ir_ready, "R1 ir_ready", int'(ir_ready), 0);

        // R2: unknown unit code 3 never issues, marks nothing busy
        @(negedge clk);
        ir_valid = 1'b1; ir_unit = 2'd3; ir_dst = 5'd9;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(!ir_ready, "R2 code3 ir_ready", int'(ir_ready), 0);
            @(negedge clk);
        end
        #1;
        chk(reg_busy == '0, "R2 code3 reg_busy", int'(reg_busy), 0);

        // R7/R11: adder takes one instruction per cycle
        issue(U_ADD, 1, 20, 21, ea); expect_cmp(ea + 4, U_ADD, 1);
        issue(U_ADD, 2, 20, 21, eb); expect_cmp(eb + 4, U_ADD, 2);
        issue(U_ADD, 3, 20, 21, ec); expect_cmp(ec + 4, U_ADD, 3);
        chk(eb == ea + 1, "R11 add refill edge", eb - ea, 1);
        chk(ec == eb + 1, "R7 add back-to-back", ec - eb, 1);
        idle_until(cyc + 10);

        // R8: DIV F0; ADD F10,F0,F8 waits; independent MUL F12 overtakes
        issue(U_DIV, 0, 2, 4, ea);   expect_cmp(ea + 6, U_DIV, 0);
        issue(U_ADD, 10, 0, 8, eb);  expect_cmp(ea + 11, U_ADD, 10);
        issue(U_MUL, 12, 8, 14, ec); expect_cmp(ec + 4, U_MUL, 12);
        chk(eb == ea + 1, "R2 RAW does not block issue", eb - ea, 1);
        chk(ec == ea + 2, "R8 independent issue", ec - ea, 2);
        idle_until(cyc + 14);

        // R3/R4: WAW stalls ADD F0; MUL F20 behind it is blocked too
        issue(U_DIV, 0, 2, 4, ea);    expect_cmp(ea + 6, U_DIV, 0);
        @(negedge clk);
        ir_valid = 1'b0;
        #1;
        chk(reg_busy[0] == 1'b1, "R3 busy after issue", int'(reg_busy[0]), 1);
        issue(U_ADD, 0, 10, 12, eb);  expect_cmp(eb + 4, U_ADD, 0);
        issue(U_MUL, 20, 21, 22, ec); expect_cmp(ec + 4, U_MUL, 20);
        chk(eb == ea + 8, "R3 WAW issue edge", eb - ea, 8);
        chk(ec == eb + 1, "R4 head-of-line", ec - eb, 1);
        idle_until(cyc + 10);

        // R7/R11: multiplier non-pipelined, slot refill on dispatch
        issue(U_MUL, 1, 20, 21, ea); expect_cmp(ea + 4, U_MUL, 1);
        issue(U_MUL, 2, 20, 21, eb); expect_cmp(ea + 9, U_MUL, 2);
        issue(U_MUL, 3, 20, 21, ec); expect_cmp(ea + 14, U_MUL, 3);
        chk(eb == ea + 1, "R11 mul refill edge", eb - ea, 1);
        chk(ec == ea + 6, "R7 mul structural stall", ec - ea, 6);
        idle_until(cyc + 12);

        // R9/R5: self-source ADD F5,F5,F6 does not wait on itself
        issue(U_ADD, 5, 5, 6, ea); expect_cmp(ea + 4, U_ADD, 5);
        @(negedge clk);
        ir_valid = 1'b0;
        #1;
        chk(disp_valid[U_ADD] == 1'b1, "R5 dispatch next cycle", int'(disp_valid[U_ADD]), 1);
        chk(disp_rs1[U_ADD*REG_W +: REG_W] == 5'd5, "R5 read port 1",
            int'(disp_rs1[U_ADD*REG_W +: REG_W]), 5);
        chk(disp_rs2[U_ADD*REG_W +: REG_W] == 5'd6, "R5 read port 2",
            int'(disp_rs2[U_ADD*REG_W +: REG_W]), 6);
        idle_until(cyc + 8);

        // R9: later DIV F8 must not delay waiting MUL F6,F0,F8
        issue(U_ADD, 0, 1, 2, ea);  expect_cmp(ea + 4, U_ADD, 0);
        issue(U_MUL, 6, 0, 8, eb);  expect_cmp(ea + 9, U_MUL, 6);
        issue(U_DIV, 8, 3, 4, ec);  expect_cmp(ec + 6, U_DIV, 8);
        chk(ec == ea + 2, "R9 WAR writer issues", ec - ea, 2);
        idle_until(cyc + 12);

        // R10: issue during producer's completion cycle
        issue(U_ADD, 3, 1, 2, ea); expect_cmp(ea + 4, U_ADD, 3);
        idle_until(ea + 3);
        issue(U_MUL, 7, 3, 1, ed); expect_cmp(ea + 9, U_MUL, 7);
        chk(ed == ea + 5, "R10 issue edge", ed - ea, 5);
        idle_until(cyc + 14);

        #1;
        chk(exp_q.size() == 0, "R6 all completions seen", exp_q.size(), 0);
        chk(reg_busy == '0, "R3 all registers released", int'(reg_busy), 0);
        chk(stage_busy == '0, "R5 all slots drained", int'(stage_busy), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule